// File: doc/BRIEF.md
# Serial DAC Control Register Port

This block takes control words arriving on a three-wire serial link (data, bit clock, write strobe) and turns each one into a 10-bit code held in one of two registers. Register 0 holds the code for the gain-control converter. Register 1 holds the code for a general-purpose converter. Both codes are always present on parallel outputs, ready to drive the converters.

The serial pins are asynchronous to the block. Each one passes through a two-flop synchronizer in the system clock domain, and the block acts on the rising edges of the synchronized serial clock and write strobe. The system clock must run at least four times as fast as the serial clock.

An active-low clear input empties the shift register and both code registers at once, without waiting for a clock edge. The synchronous active-high system reset clears the whole block. Each committed write raises a one-cycle pulse and reports which register changed.

Top module: `serdac_ctrl_port`

## Requirements
- R1: A frame is 12 bits, sent first to last: a start bit, an address bit, then data bits D9 down to D0. The start bit's value has no effect on the result.
- R2: On a commit, an address bit of 0 loads the 10 data bits into gain_code and an address bit of 1 loads them into aux_code. The other register keeps its value.
- R3: `sd` is taken at the rising edge of `sclk`. A change on `sd` while `sclk` is high and after that edge has no effect.
- R4: Shifting bits in with `sclk` alone leaves gain_code, aux_code and upd_pulse unchanged. Only a rising edge on `wrt` commits a word.
- R5: When more than 12 bits arrive before a commit, only the last 12 count.
- R6: When fewer than 12 bits arrive before a commit, the word is built from the new bits plus the older shift contents below them, and it is committed with no error indication.
- R7: While `clr_n` is low, gain_code, aux_code and the shift contents read as zero at once, without waiting for a clock edge.
- R8: A commit drives upd_pulse high for exactly one cycle. upd_sel carries the address bit (0 = gain_code, 1 = aux_code). The pulse and the new code both appear after the third rising clock edge that follows the rise of `wrt`.
- R9: A synchronous `rst` clears gain_code, aux_code, upd_pulse and the shift contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| clr_n | input | 1 | Asynchronous clear of the shift and code registers, active low |
| sd | input | 1 | Serial data |
| sclk | input | 1 | Serial bit clock, idles low |
| wrt | input | 1 | Write strobe; its rising edge commits the word |
| gain_code | output | 10 | Code register 0, for the gain-control converter |
| aux_code | output | 10 | Code register 1, for the general-purpose converter |
| upd_pulse | output | 1 | One-cycle pulse on each commit |
| upd_sel | output | 1 | Index of the register just written |

## Verification
A pin edge takes two clock edges to pass the synchronizer and one more to reach a register. A bit on `sd` therefore enters the shift register at the third rising clock edge after `sclk` rises, and a commit shows on the outputs after the third rising edge after `wrt` rises. The bench drives every pin on a falling clock edge. It counts rising edges from the strobe and samples 1 ns after edges two, three and four, so it can show that the pulse is absent before the commit, present for exactly one cycle and gone afterwards. It holds `sd` steady for four cycles on each side of the `sclk` rise before it scrambles the line. The asynchronous clear is checked 1 ns after `clr_n` falls, with no clock edge in between.

// File: rtl/serdac_pkg.sv
`timescale 1ns/1ps
package serdac_pkg;
  localparam int CODE_W_DEF  = 10;
  localparam int SEL_W       = 1;
  localparam int SYNC_STAGES = 2;

  typedef enum logic {
    SYNC_LEVEL = 1'b0,
    SYNC_RISE  = 1'b1
  } sync_mode_e;
endpackage

// File: rtl/serdac_sync.sv
`timescale 1ns/1ps
module serdac_sync
  import serdac_pkg::*;
#(
  parameter int         W      = 1,
  parameter int         STAGES = SYNC_STAGES,
  parameter sync_mode_e MODE   = SYNC_LEVEL
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pin,
  output logic [W-1:0] q
);
  // rise mode keeps one extra flop as the "previous" sample
  localparam int DEPTH = (MODE == SYNC_RISE) ? STAGES + 1 : STAGES;

  logic [W-1:0] chain [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < DEPTH; k++) chain[k] <= '0;
    end else begin
      chain[0] <= pin;
      for (int k = 1; k < DEPTH; k++) chain[k] <= chain[k-1];
    end
  end

  generate
    if (MODE == SYNC_RISE) begin : g_rise
      assign q = chain[STAGES-1] & ~chain[STAGES];

      for (genvar b = 0; b < W; b++) begin : g_chk
        // an edge pulse can never last two cycles
        p_edge_single_r8: assert property (@(posedge clk) disable iff (rst)
          q[b] |=> !q[b]);
      end
    end else begin : g_level
      assign q = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/serdac_shift.sv
`timescale 1ns/1ps
module serdac_shift #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_n,
  input  logic         en,
  input  logic         din,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n)   q <= '0;
    else if (rst) q <= '0;
    else if (en)  q <= {q[W-2:0], din};
  end

  p_shift_hold_r3: assert property (@(posedge clk) disable iff (rst || !clr_n)
    !en |=> $stable(q));

  p_shift_moves_r5: assert property (@(posedge clk) disable iff (rst || !clr_n)
    en |=> (q[W-1:1] == $past(q[W-2:0])));
endmodule

// File: rtl/serdac_bank.sv
`timescale 1ns/1ps
module serdac_bank #(
  parameter int CODE_W = 10,
  parameter int SEL_W  = 1,
  localparam int NREG  = 1 << SEL_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   clr_n,
  input  logic                   we,
  input  logic [SEL_W-1:0]       sel,
  input  logic [CODE_W-1:0]      din,
  output logic [NREG*CODE_W-1:0] codes,
  output logic                   pulse,
  output logic [SEL_W-1:0]       pulse_sel
);
  logic [CODE_W-1:0] regs [NREG];

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we) begin
      for (int i = 0; i < NREG; i++)
        if (sel == SEL_W'(i)) regs[i] <= din;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pulse     <= 1'b0;
      pulse_sel <= '0;
    end else begin
      pulse <= we;
      if (we) pulse_sel <= sel;
    end
  end

  generate
    for (genvar i = 0; i < NREG; i++) begin : g_out
      assign codes[i*CODE_W +: CODE_W] = regs[i];

      p_other_held_r2: assert property (@(posedge clk) disable iff (rst || !clr_n)
        (we && sel != SEL_W'(i)) |=> $stable(regs[i]));

      p_idle_hold_r4: assert property (@(posedge clk) disable iff (rst || !clr_n)
        !we |=> $stable(regs[i]));
    end
  endgenerate

  p_pulse_single_r8: assert property (@(posedge clk) disable iff (rst)
    pulse |=> !pulse);
endmodule

// File: rtl/serdac_ctrl_port.sv
`timescale 1ns/1ps
module serdac_ctrl_port
  import serdac_pkg::*;
#(
  parameter int CODE_W  = CODE_W_DEF,
  parameter int STAGES  = SYNC_STAGES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_n,
  input  logic              sd,
  input  logic              sclk,
  input  logic              wrt,
  output logic [CODE_W-1:0] gain_code,
  output logic [CODE_W-1:0] aux_code,
  output logic              upd_pulse,
  output logic              upd_sel
);
  // the start bit is never used, so only address + data are kept
  localparam int KEEP_W = CODE_W + SEL_W;
  localparam int NREG   = 1 << SEL_W;

  logic              sd_s;
  logic [1:0]        edges;   // [0] serial clock rise, [1] strobe rise
  logic [KEEP_W-1:0] word;
  logic [NREG*CODE_W-1:0] codes;
  logic [SEL_W-1:0]  psel;

  serdac_sync #(.W(1), .STAGES(STAGES), .MODE(SYNC_LEVEL)) u_sd_sync (
    .clk(clk), .rst(rst), .pin(sd), .q(sd_s)
  );

  serdac_sync #(.W(2), .STAGES(STAGES), .MODE(SYNC_RISE)) u_edge_sync (
    .clk(clk), .rst(rst), .pin({wrt, sclk}), .q(edges)
  );

  serdac_shift #(.W(KEEP_W)) u_shift (
    .clk(clk), .rst(rst), .clr_n(clr_n), .en(edges[0]), .din(sd_s), .q(word)
  );

  serdac_bank #(.CODE_W(CODE_W), .SEL_W(SEL_W)) u_bank (
    .clk(clk), .rst(rst), .clr_n(clr_n),
    .we(edges[1]), .sel(word[CODE_W +: SEL_W]), .din(word[CODE_W-1:0]),
    .codes(codes), .pulse(upd_pulse), .pulse_sel(psel)
  );

  assign gain_code = codes[CODE_W-1:0];
  assign aux_code  = codes[2*CODE_W-1:CODE_W];
  assign upd_sel   = psel[0];

  p_strobe_commits_r8: assert property (@(posedge clk) disable iff (rst || !clr_n)
    edges[1] |=> (upd_pulse && upd_sel == $past(word[CODE_W])));

  p_pulse_needs_strobe_r4: assert property (@(posedge clk) disable iff (rst)
    upd_pulse |-> $past(edges[1]));
endmodule

// File: tb/serdac_ctrl_port_bench.sv
`timescale 1ns/1ps
module serdac_ctrl_port_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic clr_n = 1'b1;
  logic sd = 1'b0, sclk = 1'b0, wrt = 1'b0;
  logic [9:0] gain_code, aux_code;
  logic upd_pulse, upd_sel;

  int errs = 0, checks = 0, pulses = 0;
  bit done = 1'b0;
  logic [10:0] model = '0;   // address + data as they should sit in the shift path
  logic [9:0]  exp_g = '0, exp_a = '0;

  always #2.5 clk = ~clk;

  serdac_ctrl_port u_serdac_ctrl_port (
    .clk(clk), .rst(rst), .clr_n(clr_n), .sd(sd), .sclk(sclk), .wrt(wrt),
    .gain_code(gain_code), .aux_code(aux_code),
    .upd_pulse(upd_pulse), .upd_sel(upd_sel)
  );

  always @(posedge clk) if (upd_pulse) pulses <= pulses + 1;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send_bit(logic b);
    @(negedge clk) sd = b;
    repeat (4) @(negedge clk);
    sclk = 1'b1;
    repeat (4) @(negedge clk);
    sd = ~b;                 // scramble after capture (R3)
    repeat (4) @(negedge clk);
    sclk = 1'b0;
    model = {model[9:0], b};
  endtask

  task automatic send_bits(logic [15:0] bits, int n);
    for (int i = n - 1; i >= 0; i--) send_bit(bits[i]);
  endtask

  task automatic strobe(string tag);
    logic a;
    a = model[10];
    if (a) exp_a = model[9:0]; else exp_g = model[9:0];
    @(negedge clk) wrt = 1'b1;
    repeat (2) @(posedge clk);
    #1 chk({tag, " R8 no pulse before third edge"}, upd_pulse, 0);
    @(posedge clk);
    #1 chk({tag, " R8 pulse"}, upd_pulse, 1);
    chk({tag, " R8 sel"}, upd_sel, a);
    chk({tag, " R2 gain_code"}, gain_code, exp_g);
    chk({tag, " R2 aux_code"}, aux_code, exp_a);
    @(posedge clk);
    #1 chk({tag, " R8 pulse one cycle"}, upd_pulse, 0);
    @(negedge clk) wrt = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    int p0;
    repeat (5) @(negedge clk);
    chk("R9 reset gain", gain_code, 0);
    chk("R9 reset aux", aux_code, 0);
    chk("R9 reset pulse", upd_pulse, 0);
    rst = 1'b0;
    repeat (4) @(negedge clk);

    // R1 R2 R3: walking one and walking zero, both registers, start bit alternating
    for (int a = 0; a < 2; a++)
      for (int k = 0; k < 10; k++) begin
        logic [9:0] d;
        d = 10'(1 << k);
        send_bits({4'b0, 1'(k), 1'(a), d}, 12);
        strobe("R1 walk1");
        send_bits({4'b0, 1'(~k), 1'(a), ~d}, 12);
        strobe("R3 walk0");
      end

    // R4: shifting alone changes nothing visible
    p0 = pulses;
    send_bits({4'b0, 1'b1, 1'b1, 10'h0F0}, 12);
    repeat (10) @(negedge clk);
    chk("R4 gain held", gain_code, exp_g);
    chk("R4 aux held", aux_code, exp_a);
    chk("R4 no pulse", pulses, p0);
    strobe("R4 commit");

    // R5: 16 bits, last 12 count
    send_bits({4'b1011, 1'b0, 1'b0, 10'h2C3}, 16);
    strobe("R5 long");

    // R6: short frame keeps older bits below
    send_bits(16'b101, 3);
    strobe("R6 short");

    // R7: asynchronous clear
    @(negedge clk) clr_n = 1'b0;
    #1 chk("R7 gain cleared", gain_code, 0);
    chk("R7 aux cleared", aux_code, 0);
    repeat (2) @(negedge clk) ;
    clr_n = 1'b1;
    model = '0; exp_g = '0; exp_a = '0;
    send_bits(16'b111, 3);
    strobe("R7 shift cleared");
    chk("R7 short after clear", gain_code, 10'h007);

    // R9: synchronous reset mid-run
    send_bits({4'b0, 1'b0, 1'b1, 10'h3A5}, 12);
    strobe("R9 pre");
    @(negedge clk) rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9 mid gain", gain_code, 0);
    chk("R9 mid aux", aux_code, 0);
    rst = 1'b0;
    model = '0; exp_g = '0; exp_a = '0;
    send_bits(16'b1, 1);
    strobe("R9 shift cleared");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule